// File: doc/BRIEF.md
# Simultaneous Multi-Channel ADC Capture Controller

This block drives a bank of serial-output analog-to-digital converters that share one conversion-start line and one serial clock, with one data line per converter. A frame-start strobe from the downstream serial transmitter begins a cycle. The controller then raises a single shared conversion-start pulse, so every channel samples at the same instant. It waits a fixed conversion time and clocks the result bits out of all converters together on the shared serial clock.

Each channel's sample arrives most significant bit first. The controller extends it to a wider word by placing the complement of the sample's least significant bit below it, which breaks up long constant runs on the outgoing line. All channel words are packed into one holding register, channel 0 in the top bits. When the register is complete, a one-cycle valid pulse tells the transmitter to take it in parallel. The register then stays untouched until the next completed readout. A frame start that arrives before readout has finished sets a sticky overrun flag and restarts the cycle.

Top module: `adc_capture_ctrl`

## Requirements
- R1: A frame start accepted while idle or done raises `adc_conv_o` for exactly one clock cycle, starting in the cycle after the strobe's clock edge.
- R2: `adc_sclk_o` stays low while converting and waiting. Its first high cycle comes CONV_CYC + SCLK_HALF + 1 cycles after the `adc_conv_o` cycle (83 with defaults).
- R3: Each readout produces exactly SAMPLE_W rising edges of `adc_sclk_o`. Each serial clock period is 2·SCLK_HALF system cycles, with SCLK_HALF of them high, for SAMPLE_W·SCLK_HALF high cycles per frame. The serial clock idles low.
- R4: All data lines are sampled together on the last system cycle of each serial-clock high phase. The first bit sampled is the sample MSB.
- R5: Channel c's 17-bit word is {sample[15:0], ~sample[0]}, with the inverted LSB at bit 0. It sits at `payload_o[(N_CH-1-c)*17 +: 17]`, so channel 0 occupies bits [271:255].
- R6: `payload_valid_o` is high for exactly one cycle. Counted in clock edges after the frame-start edge, it first reads high 1 + CONV_CYC + 2·SCLK_HALF·SAMPLE_W edges later (145 with defaults). `payload_o` holds the new data in that same cycle.
- R7: `payload_o` changes only in the cycle `payload_valid_o` is high. It keeps its value through a following frame's conversion and readout.
- R8: A frame start while converting, waiting or shifting sets `overrun_o` and restarts with a fresh conversion pulse. The restarted readout then completes with R6 timing measured from the new strobe. `overrun_o` stays low while frame starts only arrive when idle or done.
- R9: After reset, `adc_conv_o`, `adc_sclk_o`, `payload_valid_o`, `overrun_o` and all of `payload_o` are low.
- R10: Once set, `overrun_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame-start strobe from the transmitter |
| adc_sdata_i | input | N_CH (16) | Serial data, bit c from channel c |
| adc_conv_o | output | 1 | Shared conversion-start pulse |
| adc_sclk_o | output | 1 | Shared serial clock to the converters |
| payload_o | output | N_CH·(SAMPLE_W+1) (272) | Packed holding register |
| payload_valid_o | output | 1 | One-cycle pulse marking a new payload |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A wrong wait or bit count moves the valid pulse and the first serial-clock edge. This shows up as a latency mismatch within one frame, about 150 cycles. A lane that shifts the wrong way, or a word packed in the wrong order, corrupts `payload_o` at the first valid pulse. The asymmetric single-bit samples make such faults visible. A holding register that follows the shift lanes changes in the middle of the next readout and is caught there. A state machine that ignores a restart leaves `overrun_o` low and misses the new data.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/adc_cap_sclk.sv
module adc_cap_sclk #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic smp_o
);
  localparam int PER = 2 * SCLK_HALF;
  localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ph_q <= '0;
    else if (!run_i)                 ph_q <= '0;
    else if (ph_q == PW'(PER - 1))   ph_q <= '0;
    else                             ph_q <= ph_q + 1'b1;
  end

  // low half first, sample at the end of the high half
  assign sclk_o = run_i && (ph_q >= PW'(SCLK_HALF));
  assign smp_o  = run_i && (ph_q == PW'(PER - 1));
endmodule

// File: rtl/adc_cap_lane.sv
module adc_cap_lane #(
  parameter int SAMPLE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdata_i,
  output logic [SAMPLE_W:0] word_o
);
  logic [SAMPLE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[SAMPLE_W-3:0], sdata_i};
  end

  // word completed by the bit arriving on this strobe, plus inverted LSB
  assign word_o = {sh_q, sdata_i, ~sdata_i};
endmodule

// File: rtl/adc_cap_fsm.sv
module adc_cap_fsm
  import adc_cap_pkg::*;
#(
  parameter int CONV_CYC = 80,
  parameter int N_BITS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic       smp_i,
  output cap_state_e state_o,
  output logic       load_o,
  output logic       overrun_o
);
  localparam int WCW = $clog2(CONV_CYC + 1);
  localparam int BCW = $clog2(N_BITS + 1);

  cap_state_e     state_q, state_d;
  logic [WCW-1:0] wait_q;
  logic [BCW-1:0] bit_q;
  logic           ovr_q;
  logic           busy, last_bit;

  assign busy     = (state_q == ST_CONV) || (state_q == ST_WAIT) || (state_q == ST_SHIFT);
  assign last_bit = smp_i && (bit_q == BCW'(N_BITS - 1));

  always_comb begin
    state_d = state_q;
    if (frame_start_i) state_d = ST_CONV;
    else begin
      unique case (state_q)
        ST_CONV:  state_d = ST_WAIT;
        ST_WAIT:  if (wait_q == WCW'(CONV_CYC - 1)) state_d = ST_SHIFT;
        ST_SHIFT: if (last_bit) state_d = ST_DONE;
        ST_DONE:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      bit_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= (state_q == ST_WAIT && !frame_start_i) ? wait_q + 1'b1 : '0;
      if (state_q != ST_SHIFT || frame_start_i) bit_q <= '0;
      else if (smp_i)                            bit_q <= bit_q + 1'b1;
      if (frame_start_i && busy) ovr_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign load_o    = (state_q == ST_SHIFT) && last_bit && !frame_start_i;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int N_CH      = 16,
  parameter int SAMPLE_W  = 16,
  parameter int CONV_CYC  = 80,
  parameter int SCLK_HALF = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         frame_start_i,
  input  logic [N_CH-1:0]              adc_sdata_i,
  output logic                         adc_conv_o,
  output logic                         adc_sclk_o,
  output logic [N_CH*(SAMPLE_W+1)-1:0] payload_o,
  output logic                         payload_valid_o,
  output logic                         overrun_o
);
  localparam int WW    = SAMPLE_W + 1;
  localparam int PAY_W = N_CH * WW;

  cap_state_e       state;
  logic             smp, load, run;
  logic [PAY_W-1:0] packed_w, payload_q;

  assign run = (state == ST_SHIFT);

  adc_cap_fsm #(.CONV_CYC(CONV_CYC), .N_BITS(SAMPLE_W)) u_fsm (
    .clk_i, .rst_ni, .frame_start_i,
    .smp_i(smp), .state_o(state), .load_o(load), .overrun_o
  );

  adc_cap_sclk #(.SCLK_HALF(SCLK_HALF)) u_sclk (
    .clk_i, .rst_ni, .run_i(run), .sclk_o(adc_sclk_o), .smp_o(smp)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    logic [WW-1:0] word;
    adc_cap_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk_i, .rst_ni, .shift_i(smp), .sdata_i(adc_sdata_i[c]), .word_o(word)
    );
    assign packed_w[(N_CH-1-c)*WW +: WW] = word;  // channel 0 on top
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   payload_q <= '0;
    else if (load) payload_q <= packed_w;
  end

  assign adc_conv_o      = (state == ST_CONV);
  assign payload_valid_o = (state == ST_DONE);
  assign payload_o       = payload_q;
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
  parameter int PAY_W = 272
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adc_conv_o,
  input logic             adc_sclk_o,
  input logic             payload_valid_o,
  input logic             overrun_o,
  input logic [PAY_W-1:0] payload_o
);
  AST_CONV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |=> !adc_conv_o); // R1
  AST_NO_SCLK_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |-> !adc_sclk_o); // R2
  AST_NO_SCLK_AT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    payload_valid_o |-> !adc_sclk_o); // R3
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    payload_valid_o |=> !payload_valid_o); // R6
  AST_PAYLOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !payload_valid_o |-> $stable(payload_o)); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R10
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.PAY_W(N_CH*(SAMPLE_W+1))) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_conv_o(adc_conv_o), .adc_sclk_o(adc_sclk_o),
  .payload_valid_o(payload_valid_o), .overrun_o(overrun_o), .payload_o(payload_o)
);

// File: tb/adc_capture_ctrl_bench.sv
module adc_capture_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 16, SW = 16, CONV = 80, HALF = 2;
  localparam int PAY_W = N_CH * (SW + 1);
  localparam int LAT = 1 + CONV + 2 * HALF * SW;
  localparam int NV = 6;
  // {base, mix}: channel sample = base ^ (mix*(c+1))
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000, 16'h0000}, {16'hFFFF, 16'h0000}, {16'h0001, 16'h0000},
    {16'h8000, 16'h0000}, {16'hA5A5, 16'h1357}, {16'h3C0F, 16'h0F01}};

  logic clk = 0, rst_n = 0, fs = 0;
  logic [N_CH-1:0] sdata;
  logic conv, sclk, valid, ovr;
  logic [PAY_W-1:0] pay;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] cur_b = '0, cur_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_capture_ctrl u_adc_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .adc_sdata_i(sdata),
    .adc_conv_o(conv), .adc_sclk_o(sclk), .payload_o(pay),
    .payload_valid_o(valid), .overrun_o(ovr));

  function automatic logic [15:0] samp(input logic [15:0] b, input logic [15:0] m, input int c);
    return b ^ 16'(m * (c + 1));
  endfunction

  function automatic logic [PAY_W-1:0] exp_pay(input logic [15:0] b, input logic [15:0] m);
    logic [PAY_W-1:0] p = '0;
    for (int c = 0; c < N_CH; c++) begin
      logic [15:0] s = samp(b, m, c);
      p[(N_CH-1-c)*17 +: 17] = {s, ~s[0]};
    end
    return p;
  endfunction

  // behavioural converters: latch on start, next bit on serial-clock fall
  logic [15:0] held [N_CH];
  int bit_idx = 15;
  always @(posedge conv or negedge sclk) begin
    if (conv) begin
      for (int c = 0; c < N_CH; c++) held[c] <= samp(cur_b, cur_m, c);
      bit_idx <= 15;
    end else if (bit_idx > 0) bit_idx <= bit_idx - 1;
  end
  always_comb for (int c = 0; c < N_CH; c++) sdata[c] = held[c][bit_idx[3:0]];

  // port monitors
  int conv_cnt = 0, rise_cnt = 0, hi_cnt = 0, valid_cnt = 0, t_conv = 0, t_first = 0;
  logic sclk_prev = 0, first_seen = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    sclk_prev <= sclk;
    if (conv) begin conv_cnt <= conv_cnt + 1; t_conv <= cyc; first_seen <= 0; end
    if (sclk) hi_cnt <= hi_cnt + 1;
    if (sclk && !sclk_prev) begin
      rise_cnt <= rise_cnt + 1;
      if (!first_seen) begin t_first <= cyc; first_seen <= 1; end
    end
    if (valid) valid_cnt <= valid_cnt + 1;
  end

  task automatic check(input string req, input logic [PAY_W-1:0] act, input logic [PAY_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_fs();
    @(negedge clk) fs = 1;
    @(posedge clk); #1 fs = 0;
  endtask

  // returns edges from strobe edge to first valid, -1 on timeout
  task automatic wait_valid(output int lat);
    lat = -1;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk); #1;
      if (valid) begin lat = k; break; end
    end
  endtask

  task automatic frame(input string tag_lat, input int b, input int m);
    int lat, c0, r0, h0, v0;
    cur_b = 16'(b); cur_m = 16'(m);
    c0 = conv_cnt; r0 = rise_cnt; h0 = hi_cnt; v0 = valid_cnt;
    pulse_fs();
    wait_valid(lat);
    check({tag_lat, " latency"}, PAY_W'(lat), PAY_W'(LAT));
    check("R5 R4 payload", pay, exp_pay(16'(b), 16'(m)));
    @(posedge clk); #1;
    check("R1 conv cycles", PAY_W'(conv_cnt - c0), PAY_W'(1));
    check("R3 sclk rises", PAY_W'(rise_cnt - r0), PAY_W'(SW));
    check("R3 sclk high cycles", PAY_W'(hi_cnt - h0), PAY_W'(SW * HALF));
    check("R6 valid width", PAY_W'(valid_cnt - v0), PAY_W'(1));
    check("R2 conv to first sclk", PAY_W'(t_first - t_conv), PAY_W'(CONV + HALF + 1));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [PAY_W-1:0] snap;
    int lat;
    #(CLK_PERIOD * 3);
    // R9 reset state
    check("R9 conv", PAY_W'(conv), '0);
    check("R9 sclk", PAY_W'(sclk), '0);
    check("R9 valid", PAY_W'(valid), '0);
    check("R9 overrun", PAY_W'(ovr), '0);
    check("R9 payload", pay, '0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    for (int v = 0; v < NV; v++) frame("R6", int'(VEC[v][31:16]), int'(VEC[v][15:0]));
    check("R8 no overrun on clean frames", PAY_W'(ovr), '0);

    // R7 hold while idle and through next readout
    snap = pay;
    repeat (40) @(posedge clk);
    #1 check("R7 hold idle", pay, snap);
    cur_b = 16'h1234; cur_m = 16'h0101;
    pulse_fs();
    repeat (110) @(posedge clk);
    #1 check("R7 hold mid readout", pay, snap);
    wait_valid(lat);
    check("R7 new payload", pay, exp_pay(16'h1234, 16'h0101));

    // R8 restart mid readout
    repeat (5) @(posedge clk);
    cur_b = 16'h0F0F; cur_m = 16'h0000;
    pulse_fs();
    repeat (100) @(posedge clk);
    cur_b = 16'hC001; cur_m = 16'h0203;
    pulse_fs();
    #1 check("R8 overrun set", PAY_W'(ovr), PAY_W'(1));
    wait_valid(lat);
    check("R8 restart latency", PAY_W'(lat), PAY_W'(LAT));
    check("R8 restart payload", pay, exp_pay(16'hC001, 16'h0203));

    // R10 sticky through a clean frame
    repeat (5) @(posedge clk);
    frame("R6", 16'h7E81, 16'h0011);
    check("R10 overrun sticky", PAY_W'(ovr), PAY_W'(1));

    summary();
  end
endmodule